// File: doc/BRIEF.md
# Trackball Motion and Press Decoder

This block connects a four-switch trackball to a chip's logic. The trackball has one contact for each direction of roll, and each contact opens and closes repeatedly while the ball turns that way. A fifth contact closes while the ball is pushed down. The block holds the supply lines of the two axis contact groups and of the press contact at logic 1. It passes each of the five returned lines through a two-flop synchronizer and a stability filter. It treats every accepted transition of a direction line as one step of movement.

Steps go into two signed counters, one for X and one for Y. The counters stop at their limits and do not wrap. A consumer pulses a read strobe. The block then copies both counters to its outputs and restarts them from zero in the same cycle. A step that is accepted in that same cycle goes into the fresh count. The press contact gives one-cycle press and release pulses and a sticky pressed flag, which stays set until it is cleared by a strobe.

Top module: `trackball_decoder`

## Requirements
- R1: `x_common_drv`, `y_common_drv` and `press_drv` are registered copies of `enable`. They are 1 one cycle after `enable` is 1 and 0 one cycle after it is 0. Reset drives them to 0.
- R2: After a synchronous reset, `x_count` and `y_count` read 0, and `pressed`, `press_pulse` and `release_pulse` read 0.
- R3: An input level is accepted only after it has held for `STABLE_CYCLES` consecutive cycles past the two-flop synchronizer. A level change that lasts fewer cycles produces no step and no press event.
- R4: Every accepted transition of `right_in`, rising or falling, adds 1 to the X count, and every accepted transition of `left_in` subtracts 1 from it. `up_in` and `down_in` do the same for Y.
- R5: A count at its positive limit (+127 for 8 bits) stays there when more increments arrive.
- R6: A count at its negative limit (-128 for 8 bits) stays there when more decrements arrive.
- R7: When `read_xy` is high at a clock edge, `x_count`/`y_count` take the counts accumulated before that edge and the counters restart from zero. A step accepted at that same edge goes into the next read.
- R8: An accepted rising edge of `press_in` gives exactly one cycle of `press_pulse` and sets `pressed`. An accepted falling edge gives exactly one cycle of `release_pulse`.
- R9: `pressed` stays 1 through a release and clears only on `clear_press`. If a press event and `clear_press` fall in the same cycle, the press event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Turns the contact supply lines on |
| x_common_drv | output | 1 | Supply to the X-axis contacts |
| y_common_drv | output | 1 | Supply to the Y-axis contacts |
| press_drv | output | 1 | Supply to the press contact |
| right_in | input | 1 | Right contact, 1 while closed |
| left_in | input | 1 | Left contact, 1 while closed |
| up_in | input | 1 | Up contact, 1 while closed |
| down_in | input | 1 | Down contact, 1 while closed |
| press_in | input | 1 | Press contact, 1 while the ball is pushed |
| read_xy | input | 1 | Snapshot and restart the counts |
| clear_press | input | 1 | Clears the sticky pressed flag |
| x_count | output | CNT_WIDTH | Last X snapshot, two's complement |
| y_count | output | CNT_WIDTH | Last Y snapshot, two's complement |
| press_pulse | output | 1 | One-cycle press event |
| release_pulse | output | 1 | One-cycle release event |
| pressed | output | 1 | Sticky press flag |

## Verification
The bench rolls the counters far past both limits. A design that wrapped would return a small or sign-flipped count instead of +127 or -128. It sends glitches that last one cycle less than the filter window. A filter that was off by one would turn them into phantom steps. It places a step on the exact edge that carries the read strobe. A design that cleared after applying the step would lose it, and one that applied it before the snapshot would report it one read too early. Press handling is checked by counting pulse cycles, which exposes a held level where a pulse should be, and by checking that the flag survives a release.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  // index of each raw contact inside the debouncer bank
  localparam int unsigned IN_RIGHT = 0;
  localparam int unsigned IN_LEFT  = 1;
  localparam int unsigned IN_UP    = 2;
  localparam int unsigned IN_DOWN  = 3;
  localparam int unsigned IN_PRESS = 4;
  localparam int unsigned NUM_IN   = 5;
endpackage

// File: rtl/tbd_debounce.sv
module tbd_debounce #(
  parameter int STABLE_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (STABLE_CYCLES < 2) ? 1 : $clog2(STABLE_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  logic          s1, s2, level;
  logic [CW-1:0] cnt;
  logic          flip;

  assign flip = (s2 != level) && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1     <= 1'b0;
      s2     <= 1'b0;
      level  <= 1'b0;
      cnt    <= '0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      s1     <= din;
      s2     <= s1;
      rise_o <= flip & s2;
      fall_o <= flip & ~s2;
      if (s2 == level) begin
        cnt <= '0;
      end else if (flip) begin
        level <= s2;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: a synchronized value equal to the accepted level never moves it
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (s2 == level) |=> $stable(level));
  // R4: an edge event reports the direction the accepted level really took
  p_rise_r4: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> (level && !$past(level)));
  p_fall_r4: assert property (@(posedge clk) disable iff (rst)
    fall_o |-> (!level && $past(level)));
endmodule

// File: rtl/tbd_axis_acc.sv
module tbd_axis_acc #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  input  logic             clr,
  output logic [WIDTH-1:0] snap
);
  localparam logic signed [WIDTH-1:0] MAXV = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic signed [WIDTH-1:0] MINV = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic signed [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  logic signed [WIDTH-1:0] acc, base, nxt;

  // a read restarts from zero, but the step of this cycle still lands
  always_comb begin
    base = clr ? '0 : acc;
    nxt  = base;
    if (inc && !dec && base != MAXV) nxt = base + ONE;
    else if (dec && !inc && base != MINV) nxt = base - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      snap <= '0;
    end else begin
      acc <= nxt;
      if (clr) snap <= acc;
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (acc == MAXV && !clr) |=> (acc != MINV));
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
    (acc == MINV && !clr) |=> (acc != MAXV));
  p_snapshot_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (snap == $past(acc)));
endmodule

// File: rtl/tbd_press.sv
module tbd_press (
  input  logic clk,
  input  logic rst,
  input  logic rise_ev,
  input  logic fall_ev,
  input  logic clear_press,
  output logic press_pulse,
  output logic release_pulse,
  output logic pressed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      press_pulse   <= 1'b0;
      release_pulse <= 1'b0;
      pressed       <= 1'b0;
    end else begin
      press_pulse   <= rise_ev;
      release_pulse <= fall_ev;
      if (rise_ev)          pressed <= 1'b1;
      else if (clear_press) pressed <= 1'b0;
    end
  end

  p_single_press_r8: assert property (@(posedge clk) disable iff (rst)
    press_pulse |=> !press_pulse);
  p_single_release_r8: assert property (@(posedge clk) disable iff (rst)
    release_pulse |=> !release_pulse);
  p_flag_with_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    press_pulse |-> pressed);
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (pressed && !clear_press) |=> pressed);
endmodule

// File: rtl/trackball_decoder.sv
module trackball_decoder #(
  parameter int STABLE_CYCLES = 50000,
  parameter int CNT_WIDTH     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  output logic                 x_common_drv,
  output logic                 y_common_drv,
  output logic                 press_drv,
  input  logic                 right_in,
  input  logic                 left_in,
  input  logic                 up_in,
  input  logic                 down_in,
  input  logic                 press_in,
  input  logic                 read_xy,
  input  logic                 clear_press,
  output logic [CNT_WIDTH-1:0] x_count,
  output logic [CNT_WIDTH-1:0] y_count,
  output logic                 press_pulse,
  output logic                 release_pulse,
  output logic                 pressed
);
  import tbd_pkg::*;

  logic [NUM_IN-1:0] raw, rise, fall, moved;

  assign raw[IN_RIGHT] = right_in;
  assign raw[IN_LEFT]  = left_in;
  assign raw[IN_UP]    = up_in;
  assign raw[IN_DOWN]  = down_in;
  assign raw[IN_PRESS] = press_in;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_db
    tbd_debounce #(.STABLE_CYCLES(STABLE_CYCLES)) u_db (
      .clk   (clk),
      .rst   (rst),
      .din   (raw[i]),
      .rise_o(rise[i]),
      .fall_o(fall[i])
    );
  end

  // a direction contact counts both of its edges
  assign moved = rise | fall;

  tbd_axis_acc #(.WIDTH(CNT_WIDTH)) u_x (
    .clk (clk), .rst(rst),
    .inc (moved[IN_RIGHT]), .dec(moved[IN_LEFT]),
    .clr (read_xy), .snap(x_count)
  );

  tbd_axis_acc #(.WIDTH(CNT_WIDTH)) u_y (
    .clk (clk), .rst(rst),
    .inc (moved[IN_UP]), .dec(moved[IN_DOWN]),
    .clr (read_xy), .snap(y_count)
  );

  tbd_press u_press (
    .clk          (clk),
    .rst          (rst),
    .rise_ev      (rise[IN_PRESS]),
    .fall_ev      (fall[IN_PRESS]),
    .clear_press  (clear_press),
    .press_pulse  (press_pulse),
    .release_pulse(release_pulse),
    .pressed      (pressed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x_common_drv <= 1'b0;
      y_common_drv <= 1'b0;
      press_drv    <= 1'b0;
    end else begin
      x_common_drv <= enable;
      y_common_drv <= enable;
      press_drv    <= enable;
    end
  end

  p_drive_on_r1: assert property (@(posedge clk) disable iff (rst)
    enable |=> (x_common_drv && y_common_drv && press_drv));
  p_drive_off_r1: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !(x_common_drv || y_common_drv || press_drv));
  p_events_apart_r8: assert property (@(posedge clk) disable iff (rst)
    !(press_pulse && release_pulse));
endmodule

// File: tb/trackball_decoder_tb.sv
module trackball_decoder_tb;
  localparam int DB = 4;
  localparam int W  = 8;
  localparam int SETTLE = DB + 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic x_drv, y_drv, p_drv;
  logic [3:0] dirs = 4'b0;   // 0 right, 1 left, 2 up, 3 down
  logic press_in = 1'b0;
  logic read_xy = 1'b0;
  logic clear_press = 1'b0;
  logic [W-1:0] x_count, y_count;
  logic press_pulse, release_pulse, pressed;

  always #2 clk = ~clk;

  trackball_decoder #(.STABLE_CYCLES(DB), .CNT_WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .enable(enable),
    .x_common_drv(x_drv), .y_common_drv(y_drv), .press_drv(p_drv),
    .right_in(dirs[0]), .left_in(dirs[1]), .up_in(dirs[2]), .down_in(dirs[3]),
    .press_in(press_in), .read_xy(read_xy), .clear_press(clear_press),
    .x_count(x_count), .y_count(y_count),
    .press_pulse(press_pulse), .release_pulse(release_pulse), .pressed(pressed)
  );

  typedef struct {
    int    x;
    int    y;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int exp_x = 0;
  int exp_y = 0;
  bit done = 1'b0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  // driver: toggle one direction contact and update the model
  task automatic step_dir(int idx);
    dirs[idx] = ~dirs[idx];
    case (idx)
      0: exp_x = sat(exp_x + 1);
      1: exp_x = sat(exp_x - 1);
      2: exp_y = sat(exp_y + 1);
      default: exp_y = sat(exp_y - 1);
    endcase
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic pulse_read();
    read_xy = 1'b1;
    @(negedge clk);
    read_xy = 1'b0;
  endtask

  task automatic do_read(string tag);
    item_t it;
    it.x = exp_x; it.y = exp_y; it.tag = tag;
    q.push_back(it);
    exp_x = 0; exp_y = 0;
    pulse_read();
  endtask

  // monitor: each read strobe yields one snapshot to compare
  initial begin
    forever begin
      @(posedge clk);
      if (read_xy) begin
        @(negedge clk);
        if (q.size() == 0) begin
          check("R7 unexpected read", 1, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          check({it.tag, " x"}, int'($signed(x_count)), it.x);
          check({it.tag, " y"}, int'($signed(y_count)), it.y);
        end
      end
    end
  end

  task automatic count_pulses(output int np, output int nr);
    np = 0; nr = 0;
    repeat (SETTLE + 6) begin
      @(negedge clk);
      if (press_pulse) np++;
      if (release_pulse) nr++;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int np, nr;
    item_t it;
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 x_count", int'(x_count), 0);
    check("R2 y_count", int'(y_count), 0);
    check("R2 pressed", int'(pressed), 0);
    check("R2 pulses", int'(press_pulse | release_pulse), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1: drives low while disabled, high after enable
    check("R1 drives off", int'({x_drv, y_drv, p_drv}), 0);
    enable = 1'b1;
    @(negedge clk);
    check("R1 drives on", int'({x_drv, y_drv, p_drv}), 7);

    // R4: mixed motion
    repeat (3) step_dir(0);
    repeat (2) step_dir(2);
    step_dir(1);
    repeat (4) step_dir(3);
    do_read("R4 mixed motion");
    step_dir(3);
    step_dir(0);
    do_read("R4 diagonal");

    // R3: glitches one cycle shorter than the window are ignored
    dirs[2] = ~dirs[2];
    repeat (DB - 1) @(negedge clk);
    dirs[2] = ~dirs[2];
    dirs[1] = ~dirs[1];
    repeat (2) @(negedge clk);
    dirs[1] = ~dirs[1];
    repeat (SETTLE) @(negedge clk);
    do_read("R3 glitch ignored");

    // R5 / R6: saturation
    repeat (135) step_dir(0);
    repeat (3) step_dir(2);
    do_read("R5 positive limit");
    repeat (140) step_dir(1);
    repeat (130) step_dir(3);
    do_read("R6 negative limit");
    step_dir(0);
    do_read("R6 recovery after limit");

    // R7: step accepted on the same edge as the read strobe
    dirs[0] = ~dirs[0];
    repeat (DB + 2) @(negedge clk);
    it.x = 0; it.y = 0; it.tag = "R7 read on step edge";
    q.push_back(it);
    pulse_read();
    repeat (SETTLE) @(negedge clk);
    exp_x = 1; exp_y = 0;
    do_read("R7 step kept");

    // R8: press and release
    press_in = 1'b1;
    count_pulses(np, nr);
    check("R8 press pulse count", np, 1);
    check("R8 no release on press", nr, 0);
    check("R8 pressed set", int'(pressed), 1);
    press_in = 1'b0;
    count_pulses(np, nr);
    check("R8 release pulse count", nr, 1);
    check("R8 no press on release", np, 0);
    check("R9 flag survives release", int'(pressed), 1);
    clear_press = 1'b1;
    @(negedge clk);
    clear_press = 1'b0;
    @(negedge clk);
    check("R9 flag cleared", int'(pressed), 0);
    // R3: short press glitch gives no event
    press_in = 1'b1;
    repeat (DB - 1) @(negedge clk);
    press_in = 1'b0;
    count_pulses(np, nr);
    check("R3 press glitch", np + nr, 0);
    check("R3 press glitch flag", int'(pressed), 0);

    // R1: disable drops the supply lines
    enable = 1'b0;
    @(negedge clk);
    check("R1 drives off again", int'({x_drv, y_drv, p_drv}), 0);

    repeat (4) @(negedge clk);
    check("R7 all reads seen", q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule